// File: doc/BRIEF.md
# Packed Lane Arithmetic Unit

This block is a single-cycle packed arithmetic unit for a 32-bit datapath. Each operand word is read either as four independent unsigned byte lanes or as two independent signed halfword lanes, and the selected operation is applied to every lane at once. Carries and borrows never cross a lane boundary, so each lane behaves as its own small ALU.

The operation set covers plain and saturating addition, subtraction, rounded averaging, absolute difference, minimum, maximum, a greater-than compare that produces a lane mask, truncated lane multiplication, a per-byte count of set bits, and an exchange of the two bytes inside each halfword. The result is registered: operands and opcode presented before a rising edge appear on `result` after that edge and hold until the next edge.

Top module: `simd_lane_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result` becomes 0; otherwise `result` after an edge is the function of `op`, `src_a` and `src_b` sampled at that edge (one-cycle latency).
- R2: Op 0 adds and op 1 subtracts (A minus B) each byte lane modulo 256, with no carry or borrow between bytes.
- R3: Op 2 adds each byte lane as unsigned values and clamps any sum above 255 to 0xFF.
- R4: Op 3 gives (a+b+1)>>1 per unsigned byte; op 4 gives |a-b| per unsigned byte.
- R5: Op 5 gives the unsigned minimum and op 6 the unsigned maximum per byte; op 7 writes 0xFF into a byte where A's byte is greater than B's (unsigned) and 0x00 otherwise.
- R6: Op 8 multiplies each byte pair as unsigned values and keeps the low 8 bits of each product.
- R7: Op 9 writes into each byte the number of set bits in the corresponding byte of A (B ignored).
- R8: Op 10 adds and op 11 subtracts (A minus B) each halfword lane modulo 65536, with no carry between halves.
- R9: Op 12 adds each halfword as signed values and clamps to 0x7FFF on positive overflow and 0x8000 on negative overflow.
- R10: Op 13 gives the signed average rounded up, floor((a+b+1)/2), per halfword.
- R11: Op 14 gives the signed minimum, op 15 the signed maximum, and op 16 writes 0xFFFF where A's halfword is signed-greater than B's, else 0x0000.
- R12: Op 17 multiplies each halfword pair as signed values and keeps the low 16 bits of each product.
- R13: Op 18 exchanges the two bytes within each halfword of A: result = {A[23:16], A[31:24], A[7:0], A[15:8]}.
- R14: Opcodes 19 to 31 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 5 | Operation select |
| src_a | input | 32 | First packed operand |
| src_b | input | 32 | Second packed operand |
| result | output | 32 | Registered packed result |

## Verification
The bound checker watches, every cycle, properties that hold for any operand values: compare results contain only all-ones or all-zero bytes, saturating byte sums never fall below either addend, byte minima never exceed either input, bit counts never exceed eight, the byte exchange moves A's bytes to their swapped positions, and unused opcodes give zero. Exact arithmetic values, rounding direction, lane isolation of carries, the signed clamp limits and the reset value are shown only by the bench's directed scenarios, which compare against a model built from the requirements with operands chosen at lane boundaries.

// File: rtl/simd_lane_alu_pkg.sv
package simd_lane_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD8   = 5'd0,
    OP_SUB8   = 5'd1,
    OP_ADDS8  = 5'd2,
    OP_AVG8   = 5'd3,
    OP_ABSD8  = 5'd4,
    OP_MIN8   = 5'd5,
    OP_MAX8   = 5'd6,
    OP_CMPGT8 = 5'd7,
    OP_MUL8   = 5'd8,
    OP_POPC8  = 5'd9,
    OP_ADD16  = 5'd10,
    OP_SUB16  = 5'd11,
    OP_ADDS16 = 5'd12,
    OP_AVG16  = 5'd13,
    OP_MIN16  = 5'd14,
    OP_MAX16  = 5'd15,
    OP_CMPGT16= 5'd16,
    OP_MUL16  = 5'd17,
    OP_SWAPB  = 5'd18
  } lane_op_e;
endpackage

// File: rtl/simd_byte_lane.sv
module simd_byte_lane
  import simd_lane_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  lane_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]     sum_x;
  logic [W:0]     sum_rnd;
  logic [W-1:0]   dif;
  logic [2*W-1:0] prod;
  logic           a_gt;
  logic [CW-1:0]  ones;

  assign sum_x   = {1'b0, a} + {1'b0, b};
  assign sum_rnd = sum_x + {{W{1'b0}}, 1'b1};
  assign dif     = a - b;
  assign prod    = a * b;
  assign a_gt    = a > b;

  always_comb begin
    ones = '0;
    for (int i = 0; i < W; i++) ones = ones + CW'(a[i]);
  end

  always_comb begin
    unique case (op)
      OP_ADD8:   r = sum_x[W-1:0];
      OP_SUB8:   r = dif;
      OP_ADDS8:  r = sum_x[W] ? {W{1'b1}} : sum_x[W-1:0];
      OP_AVG8:   r = sum_rnd[W:1];
      OP_ABSD8:  r = a_gt ? dif : (b - a);
      OP_MIN8:   r = a_gt ? b : a;
      OP_MAX8:   r = a_gt ? a : b;
      OP_CMPGT8: r = {W{a_gt}};
      OP_MUL8:   r = prod[W-1:0];
      OP_POPC8:  r = W'(ones);
      default:   r = '0;
    endcase
  end
endmodule

// File: rtl/simd_half_lane.sv
module simd_half_lane
  import simd_lane_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  lane_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] r
);
  logic [W:0]     sum_x;
  logic [W:0]     sum_rnd;
  logic [W:0]     dif_x;
  logic [2*W-1:0] prod;
  logic           a_gt;
  logic           ovf;
  logic [W-1:0]   sat_val;

  assign sum_x   = {a[W-1], a} + {b[W-1], b};
  assign dif_x   = {a[W-1], a} - {b[W-1], b};
  assign sum_rnd = sum_x + {{W{1'b0}}, 1'b1};
  assign prod    = a * b;
  assign a_gt    = $signed(a) > $signed(b);
  assign ovf     = sum_x[W] ^ sum_x[W-1];
  assign sat_val = sum_x[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};

  always_comb begin
    unique case (op)
      OP_ADD16:   r = sum_x[W-1:0];
      OP_SUB16:   r = dif_x[W-1:0];
      OP_ADDS16:  r = ovf ? sat_val : sum_x[W-1:0];
      OP_AVG16:   r = sum_rnd[W:1];
      OP_MIN16:   r = a_gt ? b : a;
      OP_MAX16:   r = a_gt ? a : b;
      OP_CMPGT16: r = {W{a_gt}};
      OP_MUL16:   r = prod[W-1:0];
      default:    r = '0;
    endcase
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_lane_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W  = 2 * BYTE_W;
  localparam int N_BYTES = DATA_W / BYTE_W;
  localparam int N_HALFS = DATA_W / HALF_W;

  lane_op_e          op_e;
  logic [DATA_W-1:0] byte_res;
  logic [DATA_W-1:0] half_res;
  logic [DATA_W-1:0] swap_res;
  logic [DATA_W-1:0] next_res;

  assign op_e = lane_op_e'(op);

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    simd_byte_lane #(.W(BYTE_W)) u_lane (
      .op(op_e),
      .a (src_a[g*BYTE_W +: BYTE_W]),
      .b (src_b[g*BYTE_W +: BYTE_W]),
      .r (byte_res[g*BYTE_W +: BYTE_W])
    );
  end

  for (genvar h = 0; h < N_HALFS; h++) begin : g_half
    simd_half_lane #(.W(HALF_W)) u_lane (
      .op(op_e),
      .a (src_a[h*HALF_W +: HALF_W]),
      .b (src_b[h*HALF_W +: HALF_W]),
      .r (half_res[h*HALF_W +: HALF_W])
    );
    assign swap_res[h*HALF_W +: HALF_W] =
      {src_a[h*HALF_W +: BYTE_W], src_a[h*HALF_W + BYTE_W +: BYTE_W]};
  end

  always_comb begin
    if (op <= OP_W'(OP_POPC8))        next_res = byte_res;
    else if (op <= OP_W'(OP_MUL16))   next_res = half_res;
    else if (op == OP_W'(OP_SWAPB))   next_res = swap_res;
    else                              next_res = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= next_res;
  end
endmodule

// File: rtl/simd_lane_alu_chk.sv
module simd_lane_alu_chk #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op,
  input logic [DATA_W-1:0] src_a,
  input logic [DATA_W-1:0] src_b,
  input logic [DATA_W-1:0] result
);
  localparam int NB = DATA_W / 8;

  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  function automatic bit mask_ok(input logic [DATA_W-1:0] r);
    for (int i = 0; i < NB; i++)
      if (r[i*8 +: 8] != 8'h00 && r[i*8 +: 8] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit sat_ok(input logic [DATA_W-1:0] r, a, b);
    for (int i = 0; i < NB; i++)
      if (r[i*8 +: 8] < a[i*8 +: 8] || r[i*8 +: 8] < b[i*8 +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit min_ok(input logic [DATA_W-1:0] r, a, b);
    for (int i = 0; i < NB; i++)
      if (r[i*8 +: 8] > a[i*8 +: 8] || r[i*8 +: 8] > b[i*8 +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit cnt_ok(input logic [DATA_W-1:0] r);
    for (int i = 0; i < NB; i++)
      if (r[i*8 +: 8] > 8'd8) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit swap_ok(input logic [DATA_W-1:0] r, a);
    for (int i = 0; i < NB; i++)
      if (r[i*8 +: 8] != a[(i ^ 1)*8 +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  AST_CMP_MASK: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) == OP_W'(7)) |-> mask_ok(result)); // R5
  AST_SAT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) == OP_W'(2)) |-> sat_ok(result, $past(src_a), $past(src_b))); // R3
  AST_MIN_BOUND: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) == OP_W'(5)) |-> min_ok(result, $past(src_a), $past(src_b))); // R5
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) == OP_W'(9)) |-> cnt_ok(result)); // R7
  AST_SWAP_MOVE: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) == OP_W'(18)) |-> swap_ok(result, $past(src_a))); // R13
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(op) > OP_W'(18)) |-> result == '0); // R14
endmodule

bind simd_lane_alu simd_lane_alu_chk #(.DATA_W(DATA_W), .OP_W(5)) u_chk (
  .clk(clk), .rst(rst), .op(op), .src_a(src_a), .src_b(src_b), .result(result)
);

// File: tb/tb_simd_lane_alu.sv
module tb_simd_lane_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] result;
  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  simd_lane_alu dut (.clk(clk), .rst(rst), .op(op), .src_a(src_a), .src_b(src_b), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] model(input int code, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    if (code <= 9) begin
      for (int i = 0; i < 4; i++) begin
        int x = int'(a[8*i +: 8]);
        int y = int'(b[8*i +: 8]);
        int v = 0;
        case (code)
          0: v = x + y;
          1: v = x - y;
          2: v = (x + y > 255) ? 255 : x + y;
          3: v = (x + y + 1) / 2;
          4: v = (x > y) ? x - y : y - x;
          5: v = (x < y) ? x : y;
          6: v = (x > y) ? x : y;
          7: v = (x > y) ? 255 : 0;
          8: v = x * y;
          default: for (int k = 0; k < 8; k++) v += int'(a[8*i + k]);
        endcase
        r[8*i +: 8] = v[7:0];
      end
    end else if (code <= 17) begin
      for (int i = 0; i < 2; i++) begin
        int x = int'($signed(a[16*i +: 16]));
        int y = int'($signed(b[16*i +: 16]));
        int v = 0;
        case (code)
          10: v = x + y;
          11: v = x - y;
          12: v = (x + y > 32767) ? 32767 : ((x + y < -32768) ? -32768 : x + y);
          13: v = (x + y + 1) >>> 1;
          14: v = (x < y) ? x : y;
          15: v = (x > y) ? x : y;
          16: v = (x > y) ? -1 : 0;
          default: v = x * y;
        endcase
        r[16*i +: 16] = v[15:0];
      end
    end else if (code == 18) begin
      r = {a[23:16], a[31:24], a[7:0], a[15:8]};
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: result=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag, input int code, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op = 5'(code); src_a = a; src_b = b;
    @(negedge clk);
    check(tag, result, model(code, a, b));
  endtask

  task automatic t_reset;
    rst = 1'b1; op = 5'd0; src_a = 32'hFFFF_FFFF; src_b = 32'h0101_0101;
    repeat (2) @(negedge clk);
    check("R1 reset clears", result, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 one-cycle latency", result, 32'h0000_0000);
  endtask

  task automatic t_byte_arith;
    apply("R2 byte add wrap", 0, 32'hFF01_80F0, 32'h0101_8020);
    check("R2 no carry into next byte", result, 32'h0002_0010);
    apply("R2 byte sub borrow", 1, 32'h0010_0080, 32'h0111_0081);
    check("R2 byte sub value", result, 32'hFFFF_00FF);
    apply("R3 byte sat add", 2, 32'hFF80_7F10, 32'h0180_8020);
    check("R3 clamp 0xFF", result, 32'hFFFF_FF30);
    apply("R4 byte avg round up", 3, 32'hFF01_0200, 32'hFF02_0301);
    check("R4 avg values", result, 32'hFF02_0301);
    apply("R4 byte abs diff", 4, 32'h00FF_1030, 32'hFF00_3010);
  endtask

  task automatic t_byte_order;
    apply("R5 byte min", 5, 32'h80FF_0007, 32'h7F00_0107);
    apply("R5 byte max", 6, 32'h80FF_0007, 32'h7F00_0107);
    apply("R5 byte compare", 7, 32'h80FF_0007, 32'h7F00_0107);
    check("R5 compare mask", result, 32'hFFFF_0000);
    apply("R6 byte mul", 8, 32'h10FF_0305, 32'h10FF_0407);
    check("R6 low bits", result, 32'h0001_0C23);
    apply("R7 popcount", 9, 32'hFF00_8107, 32'h1234_5678);
    check("R7 counts", result, 32'h0800_0203);
  endtask

  task automatic t_half;
    apply("R8 half add wrap", 10, 32'hFFFF_7FFF, 32'h0001_0001);
    check("R8 isolated halves", result, 32'h0000_8000);
    apply("R8 half sub", 11, 32'h0000_8000, 32'h0001_0001);
    apply("R9 sat positive", 12, 32'h7FFF_1000, 32'h0001_2000);
    check("R9 clamp 7FFF", result, 32'h7FFF_3000);
    apply("R9 sat negative", 12, 32'h8000_FFFF, 32'hFFFF_8000);
    check("R9 clamp 8000", result, 32'h8000_8000);
    apply("R10 signed avg", 13, 32'hFFFF_7FFF, 32'hFFFE_7FFF);
    check("R10 round up", result, 32'hFFFF_7FFF);
    apply("R11 signed min", 14, 32'h8000_0005, 32'h7FFF_FFFB);
    apply("R11 signed max", 15, 32'h8000_0005, 32'h7FFF_FFFB);
    apply("R11 signed compare", 16, 32'h8000_0005, 32'h7FFF_FFFB);
    check("R11 compare mask", result, 32'h0000_FFFF);
    apply("R12 half mul", 17, 32'hFFFF_0100, 32'h0003_0101);
    check("R12 low bits", result, 32'hFFFD_0100);
  endtask

  task automatic t_misc;
    apply("R13 byte swap", 18, 32'h1122_3344, 32'hDEAD_BEEF);
    check("R13 swap value", result, 32'h2211_4433);
    apply("R14 unused 19", 19, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply("R14 unused 31", 31, 32'h1234_5678, 32'h8765_4321);
    check("R14 zero", result, 32'h0);
    @(negedge clk);
    op = 5'd0; src_a = 32'h0101_0101; src_b = 32'h0101_0101; rst = 1'b1;
    @(negedge clk);
    check("R1 reset wins over op", result, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_byte_arith();
    t_byte_order();
    t_half();
    t_misc();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: result=%h expected=completion", result);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule